// File: doc/BRIEF.md
# Framed Link Receiver with CRC Check

This block sits behind a serial link deframer. It takes a stream of words marked with valid, start-of-packet and end-of-packet, and each frame in that stream has a fixed layout. The first word is a start marker. The second word carries a 16-bit sequence field. Zero or more payload words follow, and the last word holds a 32-bit CRC.

The receiver does four things with each frame:
- It drops the start marker.
- It forwards the sequence word and the payload as a new packet.
- It checks a CRC-32 over the sequence word and the payload.
- It marks the last forwarded beat with a single pass/fail flag. The CRC word itself is not passed on.

The sequence field is split into a sync flag and a 15-bit block counter, and both are presented next to the output packet.

The output lags the input by one word. The receiver holds one word back so that it can tag the word in front of the CRC as the end of the packet. Frames that are too short, frames that are cut off by a new start marker, and words that arrive outside any frame all have a defined outcome.

Top module: `frx_link_rx`

## Requirements
- R1: After a synchronous active-low reset, the following outputs are all 0: `out_valid`, `out_sop`, `out_eop`, `out_crc_ok`, `out_sync` and `out_bcnt`.
- R2: The start-marker word (the input beat with `in_sop`=1) is never forwarded. The output packet is the sequence word, marked with `out_sop`, followed by the payload words in arrival order.
- R3: The check value is a CRC-32 with these properties:
  - polynomial 0x04C11DB7 and initial value 0xFFFFFFFF;
  - bits are fed most significant first, DATA_W bits per word;
  - it covers the whole sequence word and every payload word;
  - there is no reflection and no final inversion.

  The received CRC is bits 31..0 of the `in_eop` word. When the two values differ, `out_crc_ok` is 0.
- R4: The CRC word is not forwarded. The last payload word goes out with `out_eop`=1. On that beat, `out_crc_ok`=1 only if the CRCs match and the length rule holds. `out_crc_ok` is 0 on every other beat.
- R5: `out_sync` is bit 15 of the sequence word and `out_bcnt` is bits 14..0. Both take their new value in the cycle of the output sop beat and keep it until the next output sop beat.
- R6: A frame with fewer than MIN_DATA payload words gives `out_crc_ok`=0, even when its CRC matches.
- R7: A frame that ends before a sequence word has been taken produces one beat with `out_sop`=`out_eop`=1, data 0 and `out_crc_ok`=0. This covers a start marker followed directly by an eop word, and a single sop+eop word. `out_sync` and `out_bcnt` do not change.
- R8: A valid word without `in_sop` that arrives while no frame is open produces no output.
- R9: A start marker that arrives while a frame is open closes the open output packet. Its pending word goes out with `out_eop`=1 and `out_crc_ok`=0, and the new frame is then received normally.
- R10: Cycles with `in_valid`=0 between the words of a frame do not change the output packet or the flag.
- R11: Each output beat follows an accepted input word in the previous cycle. A frame yields exactly one output beat per sequence and payload word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is valid |
| in_sop | input | 1 | Input word is the frame start marker |
| in_eop | input | 1 | Input word is the CRC word (last of frame) |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Output beat is valid |
| out_sop | output | 1 | Output beat is the sequence word |
| out_eop | output | 1 | Output beat is the last of the packet |
| out_data | output | DATA_W | Output word |
| out_crc_ok | output | 1 | Frame check result, meaningful on the eop beat |
| out_sync | output | 1 | Sync flag from the sequence field |
| out_bcnt | output | 15 | Block count from the sequence field |

## Verification
The bench builds the receiver with DATA_W=32 and MIN_DATA=2. With a minimum of two payload words, a one-payload frame that carries a correct CRC is still reported as bad, so the length rule can be told apart from the CRC comparison. Using 32-bit words lets the bench feed its own bitwise CRC model word by word with no packing. Sequence values of 0x0000, 0x7FFF, 0x8005 and 0xFFFF drive the sync flag and the block counter to both of their extremes.

// File: rtl/frx_pkg.sv
// Package: shared constants and types for the framed link receiver.
// Assumes the sequence field sits in the low 16 bits of its word and the
// received CRC in the low 32 bits of the eop word.
package frx_pkg;
    localparam int CRC_WIDTH = 32;
    localparam int SEQ_WIDTH = 16;
    localparam int BCNT_WIDTH = SEQ_WIDTH - 1;

    // Receive phase: waiting for a frame, waiting for its sequence word,
    // or inside the sequence/payload region.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEQ  = 2'd1,
        ST_BODY = 2'd2
    } frx_state_e;
endpackage

// File: rtl/frx_crc_step.sv
// Module: one CRC update over a whole data word, MSB first, non-reflected.
// Assumes POLY is given in normal (non-reversed) form.
module frx_crc_step #(
    parameter int DATA_W = 32,
    parameter int CRC_W = 32,
    parameter logic [CRC_W-1:0] POLY = 32'h04C11DB7
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc_out
);
    // Shift every data bit through the LFSR, highest bit first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic fb;
        c = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data[i];
            c = {c[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        crc_out = c;
    end
endmodule

// File: rtl/frx_seq_decode.sv
// Module: splits the sequence field into sync flag and block count.
// It loads on the strobe from the frame FSM (the output sop beat) and holds
// its value otherwise.
module frx_seq_decode
    import frx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SEQ_WIDTH-1:0]  seq_word,
    output logic                  sync,
    output logic [BCNT_WIDTH-1:0] bcnt
);
    // Capture the decoded fields on the load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync <= 1'b0;
            bcnt <= '0;
        end else if (load) begin
            sync <= seq_word[SEQ_WIDTH-1];
            bcnt <= seq_word[BCNT_WIDTH-1:0];
        end
    end

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sync) && $stable(bcnt)));
endmodule

// File: rtl/frx_frame_fsm.sv
// Module: frame parser for the receiver.
// It strips the start marker, keeps one word back so that the word before
// the CRC can carry eop, accumulates the CRC over the sequence and payload
// words, counts payload words against MIN_DATA, and registers the output beat.
// Assumes DATA_W >= 32 and MIN_DATA >= 1.
module frx_frame_fsm
    import frx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MIN_DATA = 1,
    parameter logic [CRC_WIDTH-1:0] CRC_INIT = 32'hFFFFFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [DATA_W-1:0]     in_data,
    input  logic [CRC_WIDTH-1:0]  crc_next,
    output logic [CRC_WIDTH-1:0]  crc_state,
    output logic                  seq_load,
    output logic [SEQ_WIDTH-1:0]  seq_word,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_crc_ok
);
    localparam int CNT_W = $clog2(MIN_DATA + 1);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_DATA);

    frx_state_e        state_q, state_n;
    logic [DATA_W-1:0] held_q, held_n;
    logic              hv_q, hv_n;
    logic              first_q, first_n;
    logic [CRC_WIDTH-1:0] crc_q, crc_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;

    logic              emit, e_sop, e_eop, e_ok;
    logic [DATA_W-1:0] e_data;

    assign crc_state = crc_q;
    assign seq_word  = held_q[SEQ_WIDTH-1:0];
    assign seq_load  = emit & e_sop & hv_q;

    // Next-state and output-beat selection for one accepted input word.
    always_comb begin
        state_n = state_q;
        held_n  = held_q;
        hv_n    = hv_q;
        first_n = first_q;
        crc_n   = crc_q;
        cnt_n   = cnt_q;
        emit    = 1'b0;
        e_sop   = 1'b0;
        e_eop   = 1'b0;
        e_ok    = 1'b0;
        e_data  = '0;
        if (in_valid) begin
            if (in_sop) begin
                if (hv_q) begin
                    emit   = 1'b1;
                    e_sop  = first_q;
                    e_eop  = 1'b1;
                    e_data = held_q;
                end else if (in_eop) begin
                    emit  = 1'b1;
                    e_sop = 1'b1;
                    e_eop = 1'b1;
                end
                hv_n    = 1'b0;
                first_n = 1'b0;
                crc_n   = CRC_INIT;
                cnt_n   = '0;
                state_n = in_eop ? ST_IDLE : ST_SEQ;
            end else begin
                case (state_q)
                    ST_SEQ: begin
                        if (in_eop) begin
                            emit    = 1'b1;
                            e_sop   = 1'b1;
                            e_eop   = 1'b1;
                            state_n = ST_IDLE;
                        end else begin
                            held_n  = in_data;
                            hv_n    = 1'b1;
                            first_n = 1'b1;
                            crc_n   = crc_next;
                            state_n = ST_BODY;
                        end
                    end
                    ST_BODY: begin
                        emit   = 1'b1;
                        e_sop  = first_q;
                        e_data = held_q;
                        if (in_eop) begin
                            e_eop   = 1'b1;
                            e_ok    = (crc_q == in_data[CRC_WIDTH-1:0]) && (cnt_q >= CNT_MIN);
                            hv_n    = 1'b0;
                            first_n = 1'b0;
                            state_n = ST_IDLE;
                        end else begin
                            held_n  = in_data;
                            first_n = 1'b0;
                            crc_n   = crc_next;
                            if (cnt_q < CNT_MIN) cnt_n = cnt_q + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Register the parser state and the output beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            held_q     <= '0;
            hv_q       <= 1'b0;
            first_q    <= 1'b0;
            crc_q      <= CRC_INIT;
            cnt_q      <= '0;
            out_valid  <= 1'b0;
            out_sop    <= 1'b0;
            out_eop    <= 1'b0;
            out_data   <= '0;
            out_crc_ok <= 1'b0;
        end else begin
            state_q    <= state_n;
            held_q     <= held_n;
            hv_q       <= hv_n;
            first_q    <= first_n;
            crc_q      <= crc_n;
            cnt_q      <= cnt_n;
            out_valid  <= emit;
            out_sop    <= e_sop;
            out_eop    <= e_eop;
            out_data   <= e_data;
            out_crc_ok <= e_ok;
        end
    end

    // R4
    crc_ok_on_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_crc_ok |-> (out_valid && out_eop));

    // R6
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_crc_ok) |-> ($past(cnt_q) >= CNT_MIN));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(in_valid && in_sop)) |=> !out_valid);

    // R11
    beat_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
endmodule

// File: rtl/frx_link_rx.sv
// Module: top of the framed link receiver.
// It ties together the frame parser, the per-word CRC update and the
// sequence decoder. The output beat trails the input by one word.
module frx_link_rx
    import frx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MIN_DATA = 1,
    parameter logic [CRC_WIDTH-1:0] CRC_POLY = 32'h04C11DB7,
    parameter logic [CRC_WIDTH-1:0] CRC_INIT = 32'hFFFFFFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic [DATA_W-1:0]     in_data,
    output logic                  out_valid,
    output logic                  out_sop,
    output logic                  out_eop,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_crc_ok,
    output logic                  out_sync,
    output logic [BCNT_WIDTH-1:0] out_bcnt
);
    logic [CRC_WIDTH-1:0] crc_state, crc_next;
    logic                 seq_load;
    logic [SEQ_WIDTH-1:0] seq_word;

    frx_crc_step #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_WIDTH),
        .POLY   (CRC_POLY)
    ) u_crc (
        .crc_in  (crc_state),
        .data    (in_data),
        .crc_out (crc_next)
    );

    frx_frame_fsm #(
        .DATA_W   (DATA_W),
        .MIN_DATA (MIN_DATA),
        .CRC_INIT (CRC_INIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sop     (in_sop),
        .in_eop     (in_eop),
        .in_data    (in_data),
        .crc_next   (crc_next),
        .crc_state  (crc_state),
        .seq_load   (seq_load),
        .seq_word   (seq_word),
        .out_valid  (out_valid),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_data   (out_data),
        .out_crc_ok (out_crc_ok)
    );

    frx_seq_decode u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seq_load),
        .seq_word (seq_word),
        .sync     (out_sync),
        .bcnt     (out_bcnt)
    );
endmodule

// File: tb/tb_frx_link_rx.sv
module tb_frx_link_rx;
    localparam int DW = 32;
    localparam int MIN = 2;
    localparam logic [31:0] SFI = 32'hF00DCAFE;

    // {seq[15:0], n_payload[7:0], seed[15:0], bad_crc, expected_ok}
    localparam logic [41:0] VEC [5] = '{
        {16'h8005, 8'd3, 16'h0011, 1'b0, 1'b1},
        {16'h7FFF, 8'd2, 16'h0022, 1'b0, 1'b1},
        {16'h0000, 8'd5, 16'h0033, 1'b1, 1'b0},
        {16'hFFFF, 8'd4, 16'h0044, 1'b0, 1'b1},
        {16'h1234, 8'd1, 16'h0055, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic out_valid, out_sop, out_eop, out_crc_ok, out_sync;
    logic [DW-1:0] out_data;
    logic [14:0] out_bcnt;

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] cap_data [256];
    logic        cap_sop [256];
    logic        cap_eop [256];
    logic        cap_ok [256];
    logic        cap_sync [256];
    logic [14:0] cap_bcnt [256];
    int          cap_n = 0;

    logic [31:0] exp_data [64];
    int          exp_n;

    always #10 clk = ~clk;

    frx_link_rx #(.DATA_W(DW), .MIN_DATA(MIN)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
        .out_crc_ok(out_crc_ok), .out_sync(out_sync), .out_bcnt(out_bcnt)
    );

    // Record every output beat away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 256) begin
            cap_data[cap_n] = out_data;
            cap_sop[cap_n]  = out_sop;
            cap_eop[cap_n]  = out_eop;
            cap_ok[cap_n]   = out_crc_ok;
            cap_sync[cap_n] = out_sync;
            cap_bcnt[cap_n] = out_bcnt;
            cap_n = cap_n + 1;
        end
    end

    function automatic logic [31:0] crc_ref(input logic [31:0] c_in, input logic [31:0] w);
        logic [31:0] c;
        logic fb;
        c = c_in;
        for (int i = 31; i >= 0; i--) begin
            fb = c[31] ^ w[i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
        end
        return c;
    endfunction

    task automatic chk(input bit good, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!good) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put_word(input logic sop, input logic eop, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
        end
    endtask

    // Send one frame. Fills exp_data/exp_n with the packet expected at the output.
    task automatic send_frame(input logic [15:0] seq, input int n, input logic [15:0] seed,
                              input bit bad, input bit gaps);
        logic [31:0] c;
        logic [31:0] w;
        c = 32'hFFFFFFFF;
        w = {seed, seq};
        exp_data[0] = w;
        exp_n = n + 1;
        put_word(1'b1, 1'b0, SFI);
        if (gaps) idle(2);
        put_word(1'b0, 1'b0, w);
        c = crc_ref(c, w);
        for (int i = 0; i < n; i++) begin
            w = {seed, 16'h0000} * 32'h00000193 + 32'(i) * 32'h01010101;
            exp_data[i + 1] = w;
            if (gaps) idle(1);
            put_word(1'b0, 1'b0, w);
            c = crc_ref(c, w);
        end
        if (gaps) idle(3);
        put_word(1'b0, 1'b1, bad ? (c ^ 32'h00000001) : c);
        idle(1);
    endtask

    task automatic check_frame(input int base, input bit ok_exp, input string req,
                               input logic [15:0] seq);
        chk(cap_n - base == exp_n, "R11", "beat count", 32'(cap_n - base), 32'(exp_n));
        for (int i = 0; i < exp_n && base + i < cap_n; i++) begin
            chk(cap_data[base + i] == exp_data[i], "R2", "data", cap_data[base + i], exp_data[i]);
            chk(cap_sop[base + i] == (i == 0), "R2", "sop", 32'(cap_sop[base + i]), 32'(i == 0));
            chk(cap_eop[base + i] == (i == exp_n - 1), "R4", "eop",
                32'(cap_eop[base + i]), 32'(i == exp_n - 1));
            if (i == exp_n - 1)
                chk(cap_ok[base + i] == ok_exp, req, "crc_ok at eop", 32'(cap_ok[base + i]), 32'(ok_exp));
            else
                chk(cap_ok[base + i] == 1'b0, "R4", "crc_ok before eop", 32'(cap_ok[base + i]), 32'h0);
            chk(cap_sync[base + i] == seq[15], "R5", "sync", 32'(cap_sync[base + i]), 32'(seq[15]));
            chk(cap_bcnt[base + i] == seq[14:0], "R5", "bcnt", 32'(cap_bcnt[base + i]), 32'(seq[14:0]));
        end
        idle(3);
        chk(out_sync == seq[15] && out_bcnt == seq[14:0], "R5", "sync/bcnt held",
            {16'h0, out_sync, out_bcnt}, {16'h0, seq});
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int base;
        logic [41:0] v;
        logic [31:0] c;
        string tag;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_sop && !out_eop && !out_crc_ok, "R1", "flags after reset",
            {28'h0, out_valid, out_sop, out_eop, out_crc_ok}, 32'h0);
        chk(!out_sync && out_bcnt == 15'h0, "R1", "sync/bcnt after reset",
            {16'h0, out_sync, out_bcnt}, 32'h0);

        // R8: words without a frame are ignored
        base = cap_n;
        put_word(1'b0, 1'b0, 32'h11112222);
        put_word(1'b0, 1'b1, 32'h33334444);
        put_word(1'b0, 1'b0, 32'h55556666);
        idle(3);
        chk(cap_n == base, "R8", "beats from stray words", 32'(cap_n - base), 32'h0);

        // Vector table; odd entries are sent with idle gaps (R10)
        for (int k = 0; k < 5; k++) begin
            v = VEC[k];
            tag = v[1] ? "R3" : ((32'(v[25:18]) < MIN) ? "R6" : ((k % 2 == 1) ? "R10" : "R4"));
            base = cap_n;
            send_frame(v[41:26], int'(v[25:18]), v[17:2], v[1], (k % 2 == 1));
            idle(2);
            check_frame(base, v[0], tag, v[41:26]);
        end

        // R7: start marker directly followed by eop; sync/bcnt unchanged (last seq FFFF... then 1234)
        base = cap_n;
        put_word(1'b1, 1'b0, SFI);
        put_word(1'b0, 1'b1, 32'hDEADBEEF);
        idle(3);
        chk(cap_n - base == 1, "R7", "beats for marker+eop", 32'(cap_n - base), 32'h1);
        if (cap_n - base == 1)
            chk(cap_sop[base] && cap_eop[base] && !cap_ok[base] && cap_data[base] == 0, "R7",
                "marker+eop beat", {cap_data[base][27:0], cap_sop[base], cap_eop[base], cap_ok[base], 1'b0},
                {28'h0, 4'b1100});
        chk(out_sync == 1'b0 && out_bcnt == 15'h1234, "R7", "sync/bcnt unchanged",
            {16'h0, out_sync, out_bcnt}, 32'h1234);

        // R7: single sop+eop word
        base = cap_n;
        put_word(1'b1, 1'b1, 32'h01234567);
        idle(3);
        chk(cap_n - base == 1, "R7", "beats for one-word frame", 32'(cap_n - base), 32'h1);
        if (cap_n - base == 1)
            chk(cap_sop[base] && cap_eop[base] && !cap_ok[base], "R7", "one-word beat flags",
                {29'h0, cap_sop[base], cap_eop[base], cap_ok[base]}, 32'h6);

        // R9: new start marker while a frame is open
        base = cap_n;
        c = 32'hFFFFFFFF;
        put_word(1'b1, 1'b0, SFI);
        put_word(1'b0, 1'b0, 32'hAAAA8123);
        put_word(1'b0, 1'b0, 32'h0BADF00D);
        put_word(1'b0, 1'b0, 32'hCAFED00D);
        send_frame(16'h0042, 3, 16'h0099, 1'b0, 1'b0);
        idle(2);
        chk(cap_n - base == 3 + exp_n, "R9", "beats after abort", 32'(cap_n - base), 32'(3 + exp_n));
        if (cap_n - base == 3 + exp_n) begin
            chk(cap_data[base + 2] == 32'hCAFED00D && cap_eop[base + 2] && !cap_ok[base + 2],
                "R9", "closing beat of aborted packet", cap_data[base + 2], 32'hCAFED00D);
            chk(cap_sop[base] && cap_data[base] == 32'hAAAA8123, "R9", "aborted packet start",
                cap_data[base], 32'hAAAA8123);
            check_frame(base + 3, 1'b1, "R9", 16'h0042);
        end

        idle(2);
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule